// File: doc/BRIEF.md
# Replay Buffer with Acknowledge Manager

This block keeps every framed packet that the link transmitter has sent until the far end confirms it. Framed words arrive one per cycle on a write port, each tagged with packet start and end markers; the first word of each packet carries the packet's sequence number in its low bits. A small lookup table records, for each outstanding sequence number, where the packet starts and ends in storage.

The receiver's verdicts arrive as 13-bit notifications. A positive verdict releases the named packet together with everything stored before it. A negative verdict rewinds the read side to the first word of the named packet and streams that packet and every later completed packet out of a replay port, one word per cycle, with the original markers. Occupancy is reported through FIFO-style flags, and a one-cycle error pulse marks dropped writes and notifications that name nothing stored. Timeout detection, replay counting and output link arbitration live elsewhere.

Top module: `rb_replay_buffer`

## Requirements
- R1: After reset the buffer is empty: st_empty and st_aempty are 1; st_full, st_afull, st_half, st_err and rp_valid are 0.
- R2: Each accepted write occupies one entry; st_empty is 1 at zero entries, st_aempty when entries <= AE_GAP, st_half when entries >= DEPTH/2, st_afull when entries >= DEPTH-AF_GAP, st_full at DEPTH entries (DEPTH = 2**ADDR_W).
- R3: A write while st_full is dropped, occupancy is unchanged, and st_err is 1 in the cycle after; a packet whose start word was dropped is unknown to later notifications.
- R4: On a word with wr_sop set, bits [SEQ_W-1:0] of wr_data are the packet's sequence number; a packet is known once its wr_eop word is accepted.
- R5: ntf_code bits [11:0] hold the sequence number and bit 12 the verdict: 0 is a positive acknowledgement, 1 a negative one.
- R6: A positive acknowledgement of a known packet frees that packet and every older stored packet.
- R7: A negative acknowledgement of a known packet replays, starting two cycles later, every stored word from that packet's start word through the end of the last completed packet, in order, one word per cycle with its stored sop/eop marks, leaving storage unchanged.
- R8: A notification naming a sequence number that is not a known, unfreed packet changes nothing and makes st_err 1 in the cycle after.
- R9: A negative acknowledgement accepted during a replay stops the current stream at once (no word in the following cycle) and restarts from the newly named packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Framed word present on wr_data |
| wr_sop | input | 1 | Word is the first (sequence) word of a packet |
| wr_eop | input | 1 | Word is the last word of a packet |
| wr_data | input | DATA_W | Framed word |
| ntf_valid | input | 1 | Notification present |
| ntf_code | input | SEQ_W+1 | Sequence number [11:0], verdict bit [12] |
| rp_valid | output | 1 | Replay word present |
| rp_sop | output | 1 | Replay word starts a packet |
| rp_eop | output | 1 | Replay word ends a packet |
| rp_data | output | DATA_W | Replay word |
| st_full | output | 1 | Storage full |
| st_empty | output | 1 | Storage empty |
| st_aempty | output | 1 | Occupancy at or below AE_GAP |
| st_afull | output | 1 | Occupancy within AF_GAP of full |
| st_half | output | 1 | Occupancy at least half |
| st_err | output | 1 | Dropped write or unknown notification, previous cycle |

## Verification
A wrong start address in the lookup table shows on the very first replayed word, two cycles after the negative verdict, as a word from the wrong packet or a missing sop mark. A wrong free pointer shows at the next flag change, as st_empty failing to rise after the final acknowledgement or as a stale packet still answering a negative verdict instead of raising st_err. A lost write or a wrong full computation shows one cycle after a write at capacity, as a missing error pulse or a flag that moved.

// File: rtl/rb_pkg.sv
// Shared types for the replay buffer.
package rb_pkg;
    // Verdict carried in the top bit of a notification.
    typedef enum logic {
        NTF_ACK = 1'b0,
        NTF_NAK = 1'b1
    } ntf_kind_e;

    // Packet boundary marks kept next to each stored word.
    typedef struct packed {
        logic sop;
        logic eop;
    } mark_t;
endpackage

// File: rtl/rb_store.sv
// Word storage: one write port, one registered read port.
// Assumes the caller never reads and writes the same live address
// in a way that needs write-through.
module rb_store #(
    parameter int WORD_W = 61,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Store an incoming word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Register the word at the read address.
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/rb_seq_map.sv
// Sequence map: records start/end pointers per outstanding packet,
// indexed by the low TAG_W bits of the sequence number.
// Assumes at most 2**TAG_W packets outstanding; a reused slot
// forgets the older packet.
module rb_seq_map #(
    parameter int SEQ_W = 12,
    parameter int TAG_W = 6,
    parameter int PTR_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_en,
    input  logic [SEQ_W-1:0] open_seq,
    input  logic [PTR_W-1:0] open_ptr,
    input  logic             close_en,
    input  logic [PTR_W-1:0] close_ptr,
    input  logic [SEQ_W-1:0] look_seq,
    output logic             look_hit,
    output logic [PTR_W-1:0] look_start,
    output logic [PTR_W-1:0] look_end
);
    localparam int SLOTS = 1 << TAG_W;

    logic [SLOTS-1:0] slot_vld;
    logic [SLOTS-1:0] slot_done;
    logic [SEQ_W-1:0] slot_seq   [SLOTS];
    logic [PTR_W-1:0] slot_start [SLOTS];
    logic [PTR_W-1:0] slot_end   [SLOTS];
    logic [TAG_W-1:0] cur_tag;
    logic [TAG_W-1:0] open_tag;
    logic [TAG_W-1:0] close_tag;
    logic [TAG_W-1:0] look_tag;

    assign open_tag  = open_seq[TAG_W-1:0];
    assign close_tag = open_en ? open_tag : cur_tag;
    assign look_tag  = look_seq[TAG_W-1:0];

    // Track validity and completion of each slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_vld  <= '0;
            slot_done <= '0;
            cur_tag   <= '0;
        end else begin
            if (open_en) begin
                slot_vld[open_tag]  <= 1'b1;
                slot_done[open_tag] <= 1'b0;
                cur_tag             <= open_tag;
            end
            if (close_en) slot_done[close_tag] <= 1'b1;
        end
    end

    // Hold the sequence number and pointers of each slot.
    always_ff @(posedge clk) begin
        if (open_en) begin
            slot_seq[open_tag]   <= open_seq;
            slot_start[open_tag] <= open_ptr;
        end
        if (close_en) slot_end[close_tag] <= close_ptr;
    end

    // Look up a notification's sequence number.
    always_comb begin
        look_hit   = slot_vld[look_tag] && slot_done[look_tag] &&
                     (slot_seq[look_tag] == look_seq);
        look_start = slot_start[look_tag];
        look_end   = slot_end[look_tag];
    end
endmodule

// File: rtl/rb_flags.sv
// Occupancy flags derived from the entry count.
module rb_flags #(
    parameter int ADDR_W = 10,
    parameter int AE_GAP = 16,
    parameter int AF_GAP = 16
) (
    input  logic [ADDR_W:0] used,
    output logic            full,
    output logic            empty,
    output logic            aempty,
    output logic            afull,
    output logic            half
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PW    = ADDR_W + 1;

    // Compare the count against each threshold.
    always_comb begin
        empty  = (used == '0);
        full   = (used == PW'(DEPTH));
        aempty = (used <= PW'(AE_GAP));
        afull  = (used >= PW'(DEPTH - AF_GAP));
        half   = (used >= PW'(DEPTH / 2));
    end
endmodule

// File: rtl/rb_replay_buffer.sv
// Replay buffer top: stores framed packets, frees them on positive
// verdicts and replays from a named packet on negative verdicts.
// Assumes one word per cycle in and out, and that the far end names
// only packets that were sent.
module rb_replay_buffer #(
    parameter int DATA_W = 59,
    parameter int ADDR_W = 10,
    parameter int SEQ_W  = 12,
    parameter int TAG_W  = 6,
    parameter int AE_GAP = 16,
    parameter int AF_GAP = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ntf_valid,
    input  logic [SEQ_W:0]    ntf_code,
    output logic              rp_valid,
    output logic              rp_sop,
    output logic              rp_eop,
    output logic [DATA_W-1:0] rp_data,
    output logic              st_full,
    output logic              st_empty,
    output logic              st_aempty,
    output logic              st_afull,
    output logic              st_half,
    output logic              st_err
);
    import rb_pkg::*;

    localparam int PW     = ADDR_W + 1;
    localparam int WORD_W = DATA_W + 2;

    logic [PW-1:0]     wptr, tail, commit, rd_ptr, rd_stop, used;
    logic              wr_ok, active, rd_en;
    logic              hit, known, do_ack, do_nak;
    logic [PW-1:0]     look_start, look_end;
    logic [WORD_W-1:0] rdata;
    mark_t             wmark, rmark;
    ntf_kind_e         kind;

    assign used  = wptr - tail;
    assign wr_ok = wr_valid && !st_full;
    assign wmark = '{sop: wr_sop, eop: wr_eop};
    assign kind  = ntf_kind_e'(ntf_code[SEQ_W]);
    assign known = hit && ((look_start - tail) < used);
    assign do_ack = ntf_valid && known && (kind == NTF_ACK);
    assign do_nak = ntf_valid && known && (kind == NTF_NAK);
    assign rd_en  = active && !do_nak;

    rb_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (wptr[ADDR_W-1:0]),
        .wdata ({wmark, wr_data}),
        .re    (rd_en),
        .raddr (rd_ptr[ADDR_W-1:0]),
        .rdata (rdata)
    );

    rb_seq_map #(.SEQ_W(SEQ_W), .TAG_W(TAG_W), .PTR_W(PW)) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .open_en    (wr_ok && wr_sop),
        .open_seq   (wr_data[SEQ_W-1:0]),
        .open_ptr   (wptr),
        .close_en   (wr_ok && wr_eop),
        .close_ptr  (wptr + 1'b1),
        .look_seq   (ntf_code[SEQ_W-1:0]),
        .look_hit   (hit),
        .look_start (look_start),
        .look_end   (look_end)
    );

    rb_flags #(.ADDR_W(ADDR_W), .AE_GAP(AE_GAP), .AF_GAP(AF_GAP)) u_flags (
        .used   (used),
        .full   (st_full),
        .empty  (st_empty),
        .aempty (st_aempty),
        .afull  (st_afull),
        .half   (st_half)
    );

    // Advance the write side and remember the end of the last whole packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr   <= '0;
            commit <= '0;
        end else if (wr_ok) begin
            wptr <= wptr + 1'b1;
            if (wr_eop) commit <= wptr + 1'b1;
        end
    end

    // Release storage up to the end of an acknowledged packet.
    always_ff @(posedge clk) begin
        if (!rst_n)      tail <= '0;
        else if (do_ack) tail <= look_end;
    end

    // Replay engine: rewind on a negative verdict, then read one word per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            rd_ptr   <= '0;
            rd_stop  <= '0;
            rp_valid <= 1'b0;
        end else begin
            rp_valid <= rd_en;
            if (do_nak) begin
                active  <= 1'b1;
                rd_ptr  <= look_start;
                rd_stop <= commit;
            end else if (active) begin
                rd_ptr <= rd_ptr + 1'b1;
                if (rd_ptr + 1'b1 == rd_stop) active <= 1'b0;
            end
        end
    end

    // Pulse the error flag for a dropped write or an unknown notification.
    always_ff @(posedge clk) begin
        if (!rst_n) st_err <= 1'b0;
        else        st_err <= (wr_valid && st_full) || (ntf_valid && !known);
    end

    assign rmark   = mark_t'(rdata[WORD_W-1:DATA_W]);
    assign rp_sop  = rp_valid && rmark.sop;
    assign rp_eop  = rp_valid && rmark.eop;
    assign rp_data = rdata[DATA_W-1:0];
endmodule

// File: rtl/rb_replay_buffer_chk.sv
// Port-level properties of the replay buffer, bound to every instance.
module rb_replay_buffer_chk #(
    parameter int SEQ_W = 12
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_valid,
    input logic           ntf_valid,
    input logic [SEQ_W:0] ntf_code,
    input logic           st_full,
    input logic           st_empty,
    input logic           st_aempty,
    input logic           st_afull,
    input logic           st_half,
    input logic           st_err
);
    // R2: full and empty never together.
    a_r2_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_full && st_empty));

    // R2: a full buffer also reports the lower thresholds.
    a_r2_flag_nesting: assert property (@(posedge clk) disable iff (!rst_n)
        st_full |-> (st_afull && st_half && !st_aempty));

    // R2: an accepted write leaves the buffer non-empty.
    a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !st_full && !ntf_valid) |=> !st_empty);

    // R3: a write at capacity is dropped and flagged.
    a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (st_full && wr_valid && !ntf_valid) |=> (st_full && st_err));

    // R8: with no write and no notification the occupancy does not move.
    a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_valid && !ntf_valid) |=> ($stable(st_empty) && $stable(st_full) && !st_err));
endmodule

bind rb_replay_buffer rb_replay_buffer_chk #(.SEQ_W(SEQ_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .ntf_valid (ntf_valid),
    .ntf_code  (ntf_code),
    .st_full   (st_full),
    .st_empty  (st_empty),
    .st_aempty (st_aempty),
    .st_afull  (st_afull),
    .st_half   (st_half),
    .st_err    (st_err)
);

// File: tb/sim_rb_replay_buffer.sv
module sim_rb_replay_buffer;
    localparam int DATA_W = 59;
    localparam int SEQ_W  = 12;
    localparam int DEPTH  = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              ntf_valid = 1'b0;
    logic [SEQ_W:0]    ntf_code = '0;
    logic              rp_valid, rp_sop, rp_eop;
    logic [DATA_W-1:0] rp_data;
    logic              st_full, st_empty, st_aempty, st_afull, st_half, st_err;

    int checks = 0;
    int failures = 0;
    logic [DATA_W+1:0] expq [$];

    always #4 clk = ~clk;

    rb_replay_buffer u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sop(wr_sop),
        .wr_eop(wr_eop), .wr_data(wr_data), .ntf_valid(ntf_valid),
        .ntf_code(ntf_code), .rp_valid(rp_valid), .rp_sop(rp_sop),
        .rp_eop(rp_eop), .rp_data(rp_data), .st_full(st_full),
        .st_empty(st_empty), .st_aempty(st_aempty), .st_afull(st_afull),
        .st_half(st_half), .st_err(st_err)
    );

    function automatic logic [DATA_W-1:0] wd(int seq, int i);
        return (DATA_W'(i) << SEQ_W) | DATA_W'(seq & 12'hfff);
    endfunction

    task automatic check_eq(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: write a whole packet, one word per cycle.
    task automatic send_pkt(int seq, int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            wr_valid = 1'b1;
            wr_sop   = (i == 0);
            wr_eop   = (i == len - 1);
            wr_data  = wd(seq, i);
        end
        @(negedge clk);
        wr_valid = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0;
    endtask

    // Scoreboard feed: expected replay words of a packet.
    task automatic push_words(int seq, int first, int cnt, int len);
        for (int i = first; i < first + cnt; i++)
            expq.push_back({(i == 0), (i == len - 1), wd(seq, i)});
    endtask

    task automatic notify(bit nak, int seq);
        @(negedge clk);
        ntf_valid = 1'b1;
        ntf_code  = {nak, SEQ_W'(seq)};
        @(negedge clk);
        ntf_valid = 1'b0;
    endtask

    task automatic drain(string req);
        for (int n = 0; n < 3000 && expq.size() != 0; n++) @(negedge clk);
        repeat (4) @(negedge clk);
        check_eq(req, expq.size(), 0);
    endtask

    // Monitor: compare every replayed word with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rp_valid) begin
            checks++;
            if (expq.size() == 0) begin
                failures++;
                $display("FAIL R7 unexpected word actual=%0h expected=none", rp_data);
            end else begin
                logic [DATA_W+1:0] e;
                e = expq.pop_front();
                if ({rp_sop, rp_eop, rp_data} != e) begin
                    failures++;
                    $display("FAIL R7 replay word actual=%0h expected=%0h",
                             {rp_sop, rp_eop, rp_data}, e);
                end
            end
        end
    end

    bit finished = 0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check_eq("R1 empty", st_empty, 1);
        check_eq("R1 aempty", st_aempty, 1);
        check_eq("R1 full", st_full, 0);
        check_eq("R1 half", st_half, 0);
        check_eq("R1 afull", st_afull, 0);
        check_eq("R1 err", st_err, 0);
        check_eq("R1 rp_valid", rp_valid, 0);
        rst_n = 1'b1;

        // R2 R4: three packets stored
        send_pkt(1, 3);
        send_pkt(2, 1);
        send_pkt(3, 4);
        check_eq("R2 not empty", st_empty, 0);
        check_eq("R2 aempty at 8", st_aempty, 1);

        // R5 R7: negative verdict on 2 replays 2 and 3
        push_words(2, 0, 1, 1);
        push_words(3, 0, 4, 4);
        notify(1, 2);
        check_eq("R7 no err", st_err, 0);
        drain("R7 replay from 2");

        // R6: ack 1, then 1 is gone
        notify(0, 1);
        check_eq("R6 ack ok", st_err, 0);
        notify(1, 1);
        check_eq("R8 freed packet", st_err, 1);
        push_words(3, 0, 4, 4);
        notify(1, 3);
        drain("R7 replay from 3");

        // R6: ack 3 frees 2 and 3
        notify(0, 3);
        check_eq("R6 cumulative free", st_empty, 1);
        notify(1, 77);
        check_eq("R8 unknown seq", st_err, 1);
        check_eq("R8 no change", st_empty, 1);

        // R9: restart during replay
        send_pkt(20, 6);
        send_pkt(21, 2);
        push_words(20, 0, 1, 6);
        push_words(21, 0, 2, 2);
        notify(1, 20);
        notify(1, 21);
        drain("R9 restart");
        notify(0, 21);
        check_eq("R6 empty after 21", st_empty, 1);

        // R2: almost-empty threshold
        send_pkt(30, 16);
        check_eq("R2 aempty at 16", st_aempty, 1);
        send_pkt(31, 1);
        check_eq("R2 aempty at 17", st_aempty, 0);
        check_eq("R2 half at 17", st_half, 0);
        notify(0, 31);
        check_eq("R6 empty after 31", st_empty, 1);

        // R2 R3: fill, then write at capacity
        send_pkt(40, DEPTH);
        check_eq("R2 full", st_full, 1);
        check_eq("R2 afull", st_afull, 1);
        check_eq("R2 half", st_half, 1);
        send_pkt(41, 1);
        check_eq("R3 drop err", st_err, 1);
        check_eq("R3 still full", st_full, 1);
        notify(1, 41);
        check_eq("R3 dropped unknown", st_err, 1);
        notify(0, 40);
        check_eq("R6 empty after 40", st_empty, 1);

        // R4 R5: top sequence value
        send_pkt(4095, 2);
        push_words(4095, 0, 2, 2);
        notify(1, 4095);
        drain("R4 seq 4095 replay");
        notify(0, 4095);
        check_eq("R5 ack 4095", st_empty, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule